// File: doc/BRIEF.md
# Claim/Beacon Transmit Arbiter

This block selects the transmit source of a token-ring MAC while the station is recovering the ring in the Claim or Beacon state. A write strobe places the block in either recovery state. From then on it picks, one frame at a time, between an internally built Claim or Beacon frame and a frame offered by the host through an immediate request. The host frame is only taken once the station has finished sending at least one frame of its own in the current state.

Classified receive events arrive as single-cycle strobes. During immediate service, option bits decide which of these events the block ignores. An event that is not ignored is reported one cycle later. It also either ends the immediate service or, if it is the station's own returning frame, arms an exit from the state. The exit normally happens at the next frame boundary. A per-state hold option keeps the host frames flowing until the host has no more frames ready, and only then leaves the state.

The transmit select only ever changes at a frame boundary, apart from the first entry from idle. Because of this, a frame is never cut short.

Top module: `cb_tx_arbiter`

## Requirements
- R1: A synchronous reset gives idle (both state flags low), select none (code 0), no reported event, no pending exit, and all three option bits cleared.
- R2: A function strobe moves the block into Beacon (`fn_beacon_i`) or Claim (`fn_claim_i`) on the next cycle. If both strobes are high, Beacon wins. Entry from idle sets the select to internal (code 1) on that same cycle.
- R3: In a recovery state, every frame boundary (`tx_frame_done_i`) selects internal unless R4 allows host.
- R4: A boundary selects host (code 2) only if all of these hold: the request matching the state is high (`req_claim_i` in Claim, `req_beacon_i` in Beacon); `frame_ready_i` is high; and an internal frame has completed since the later of state entry and the last ended service.
- R5: Outside entry from idle, the select changes only on the cycle after a frame boundary or a state change.
- R6: In a recovery state, a receive strobe that is not ignored appears on `rx_evt_valid_o` one cycle later, with its class on `rx_evt_class_o`. Class codes: 0 other, 1 lower claim, 2 own claim, 3 own beacon, 4 other beacon. Nothing is reported while idle.
- R7: With the no-repeat option set, classes 0, 2 and 4 are ignored while the host is selected.
- R8: With the Beacon hold option set, classes 1 and 3 are ignored while the host is selected.
- R9: An event accepted while the host is selected ends the service. The next boundary selects internal, and a further internal frame is then needed.
- R10: Class 2 in Claim or class 3 in Beacon raises `exit_pending_o`. At the next boundary the block returns to idle with select none.
- R11: While an exit is pending and the hold option of the current state is set, boundaries keep selecting host as long as R4 holds. An own-frame event during service then does not end the service. The exit happens at the first boundary where R4 fails.
- R12: A function strobe while already in recovery changes the state on the next cycle. It clears the pending exit and the completed-internal-frame record. The current select is kept until the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fn_claim_i | input | 1 | Strobe: enter Claim |
| fn_beacon_i | input | 1 | Strobe: enter Beacon |
| opt_wr_i | input | 1 | Load the three option bits |
| opt_hold_claim_i | input | 1 | Claim hold option value |
| opt_hold_beacon_i | input | 1 | Beacon hold/filter option value |
| opt_no_repeat_i | input | 1 | No-repeat filter option value |
| req_claim_i | input | 1 | Host immediate Claim request |
| req_beacon_i | input | 1 | Host immediate Beacon request |
| frame_ready_i | input | 1 | Host frame ready to send |
| tx_frame_done_i | input | 1 | One-cycle frame boundary strobe |
| rx_valid_i | input | 1 | One-cycle receive event strobe |
| rx_class_i | input | 3 | Receive event class code |
| in_claim_o | output | 1 | In Claim state |
| in_beacon_o | output | 1 | In Beacon state |
| tx_sel_o | output | 2 | Source: 0 none, 1 internal, 2 host |
| exit_pending_o | output | 1 | State exit armed |
| rx_evt_valid_o | output | 1 | Accepted receive event |
| rx_evt_class_o | output | 3 | Class of the accepted event |

## Verification
A lost or stale record of the completed internal frame shows up at the very next boundary. There, the select shows host one frame too early, right after entry, or internal when host was due. A wrong filter decision shows one cycle after the receive strobe: an event report appears or is missing. It is then confirmed at the following boundary by the select returning to internal, or by an early or late drop to idle. A corrupted exit or hold bit shows as the state flags falling one boundary too soon or too late, while `exit_pending_o` stays visible until then.

// File: rtl/cbta_pkg.sv
package cbta_pkg;

    localparam int CLS_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLAIM  = 2'd1,
        ST_BEACON = 2'd2
    } rec_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_INT  = 2'd1,
        SEL_HOST = 2'd2
    } tx_src_e;

    typedef enum logic [CLS_W-1:0] {
        RX_OTHER        = 3'd0,
        RX_LOWER_CLAIM  = 3'd1,
        RX_MY_CLAIM     = 3'd2,
        RX_MY_BEACON    = 3'd3,
        RX_OTHER_BEACON = 3'd4
    } rx_class_e;

    typedef struct packed {
        logic hold_claim;
        logic hold_beacon;
        logic no_repeat;
    } opt_s;

    typedef struct packed {
        rec_state_e st;
        tx_src_e    sel;
        logic       int_done;
        logic       exit_pend;
        logic       evt_v;
        rx_class_e  evt_c;
    } core_s;

endpackage

// File: rtl/cbta_opt_reg.sv
module cbta_opt_reg
    import cbta_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  opt_s opt_in,
    output opt_s opt_q
);
    opt_s opt_d;

    always_comb begin
        opt_d = opt_q;
        if (wr) opt_d = opt_in;
    end

    always_ff @(posedge clk) begin
        if (rst) opt_q <= '0;
        else     opt_q <= opt_d;
    end
endmodule

// File: rtl/cbta_rx_filter.sv
module cbta_rx_filter
    import cbta_pkg::*;
(
    input  rec_state_e st,
    input  logic       serving,
    input  opt_s       opt,
    input  logic       hold,
    input  logic       rx_valid,
    input  rx_class_e  rx_class,
    output logic       accept,
    output logic       exit_trig,
    output logic       end_service
);
    logic lc_or_mb;
    logic ignore;
    logic own_frame;

    always_comb begin
        lc_or_mb  = (rx_class == RX_LOWER_CLAIM) || (rx_class == RX_MY_BEACON);
        // Filtering applies only while a host frame is being served.
        ignore    = serving && ((opt.no_repeat && !lc_or_mb) ||
                                (opt.hold_beacon && lc_or_mb));
        accept    = rx_valid && (st != ST_IDLE) && !ignore;
        own_frame = ((st == ST_CLAIM)  && (rx_class == RX_MY_CLAIM)) ||
                    ((st == ST_BEACON) && (rx_class == RX_MY_BEACON));
        exit_trig = accept && own_frame;
        // A held exit lets the service run on; any other accepted event stops it.
        end_service = accept && serving && !(exit_trig && hold);
    end
endmodule

// File: rtl/cbta_core.sv
module cbta_core
    import cbta_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fn_claim,
    input  logic      fn_beacon,
    input  opt_s      opt,
    input  logic      req_claim,
    input  logic      req_beacon,
    input  logic      frame_ready,
    input  logic      tx_done,
    input  logic      rx_valid,
    input  rx_class_e rx_class,
    output core_s     r_q
);
    core_s r_d;
    logic  hold;
    logic  want_req;
    logic  accept;
    logic  exit_trig;
    logic  end_service;
    logic  idn;
    logic  xp;
    logic  host_ok;

    always_comb begin
        hold     = (r_q.st == ST_CLAIM) ? opt.hold_claim : opt.hold_beacon;
        want_req = (r_q.st == ST_CLAIM) ? req_claim : req_beacon;
    end

    cbta_rx_filter u_filt (
        .st          (r_q.st),
        .serving     (r_q.sel == SEL_HOST),
        .opt         (opt),
        .hold        (hold),
        .rx_valid    (rx_valid),
        .rx_class    (rx_class),
        .accept      (accept),
        .exit_trig   (exit_trig),
        .end_service (end_service)
    );

    always_comb begin
        r_d       = r_q;
        r_d.evt_v = 1'b0;
        r_d.evt_c = RX_OTHER;
        idn       = r_q.int_done;
        xp        = r_q.exit_pend;
        host_ok   = 1'b0;
        if (fn_beacon || fn_claim) begin
            // Beacon takes priority when both strobes coincide.
            r_d.st        = fn_beacon ? ST_BEACON : ST_CLAIM;
            r_d.int_done  = 1'b0;
            r_d.exit_pend = 1'b0;
            if ((r_q.st == ST_IDLE) || tx_done) r_d.sel = SEL_INT;
        end else if (r_q.st != ST_IDLE) begin
            if (accept) begin
                r_d.evt_v = 1'b1;
                r_d.evt_c = rx_class;
            end
            if (exit_trig)   xp  = 1'b1;
            if (end_service) idn = 1'b0;
            if (tx_done && (r_q.sel == SEL_INT)) idn = 1'b1;
            host_ok = idn && want_req && frame_ready;
            if (tx_done) begin
                if (xp && !(hold && host_ok)) begin
                    r_d.st  = ST_IDLE;
                    r_d.sel = SEL_NONE;
                    xp      = 1'b0;
                    idn     = 1'b0;
                end else begin
                    r_d.sel = host_ok ? SEL_HOST : SEL_INT;
                end
            end
            r_d.int_done  = idn;
            r_d.exit_pend = xp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st        <= ST_IDLE;
            r_q.sel       <= SEL_NONE;
            r_q.int_done  <= 1'b0;
            r_q.exit_pend <= 1'b0;
            r_q.evt_v     <= 1'b0;
            r_q.evt_c     <= RX_OTHER;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/cb_tx_arbiter.sv
module cb_tx_arbiter
    import cbta_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fn_claim_i,
    input  logic             fn_beacon_i,
    input  logic             opt_wr_i,
    input  logic             opt_hold_claim_i,
    input  logic             opt_hold_beacon_i,
    input  logic             opt_no_repeat_i,
    input  logic             req_claim_i,
    input  logic             req_beacon_i,
    input  logic             frame_ready_i,
    input  logic             tx_frame_done_i,
    input  logic             rx_valid_i,
    input  logic [CLS_W-1:0] rx_class_i,
    output logic             in_claim_o,
    output logic             in_beacon_o,
    output logic [1:0]       tx_sel_o,
    output logic             exit_pending_o,
    output logic             rx_evt_valid_o,
    output logic [CLS_W-1:0] rx_evt_class_o
);
    opt_s  opt_in;
    opt_s  opt_q;
    core_s core_q;

    always_comb begin
        opt_in.hold_claim  = opt_hold_claim_i;
        opt_in.hold_beacon = opt_hold_beacon_i;
        opt_in.no_repeat   = opt_no_repeat_i;
    end

    cbta_opt_reg u_opt (
        .clk    (clk),
        .rst    (rst),
        .wr     (opt_wr_i),
        .opt_in (opt_in),
        .opt_q  (opt_q)
    );

    cbta_core u_core (
        .clk         (clk),
        .rst         (rst),
        .fn_claim    (fn_claim_i),
        .fn_beacon   (fn_beacon_i),
        .opt         (opt_q),
        .req_claim   (req_claim_i),
        .req_beacon  (req_beacon_i),
        .frame_ready (frame_ready_i),
        .tx_done     (tx_frame_done_i),
        .rx_valid    (rx_valid_i),
        .rx_class    (rx_class_e'(rx_class_i)),
        .r_q         (core_q)
    );

    always_comb begin
        in_claim_o     = (core_q.st == ST_CLAIM);
        in_beacon_o    = (core_q.st == ST_BEACON);
        tx_sel_o       = core_q.sel;
        exit_pending_o = core_q.exit_pend;
        rx_evt_valid_o = core_q.evt_v;
        rx_evt_class_o = core_q.evt_c;
    end
endmodule

// File: rtl/cbta_chk.sv
module cbta_chk (
    input logic       clk,
    input logic       rst,
    input logic       fn_claim_i,
    input logic       fn_beacon_i,
    input logic       req_claim_i,
    input logic       req_beacon_i,
    input logic       frame_ready_i,
    input logic       tx_frame_done_i,
    input logic       rx_valid_i,
    input logic [2:0] rx_class_i,
    input logic       in_claim_o,
    input logic       in_beacon_o,
    input logic [1:0] tx_sel_o,
    input logic       exit_pending_o,
    input logic       rx_evt_valid_o,
    input logic [2:0] rx_evt_class_o
);
    // R2
    state_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({in_claim_o, in_beacon_o}));

    // R1
    idle_sel_none_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_claim_o && !in_beacon_o) |-> (tx_sel_o == 2'd0));

    // R5
    sel_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tx_frame_done_i) && !$past(fn_claim_i) &&
         !$past(fn_beacon_i)) |-> $stable(tx_sel_o));

    // R4
    host_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && tx_sel_o == 2'd2 && $past(tx_sel_o) != 2'd2) |->
        ($past(tx_frame_done_i) && $past(frame_ready_i) &&
         $past(in_claim_o ? req_claim_i : req_beacon_i)));

    // R12
    host_not_on_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(fn_claim_i) || $past(fn_beacon_i)) &&
         $past(tx_sel_o) != 2'd2) |-> (tx_sel_o != 2'd2));

    // R6
    evt_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rx_evt_valid_o) |->
        ($past(rx_valid_i) && $past(in_claim_o || in_beacon_o) &&
         rx_evt_class_o == $past(rx_class_i)));

    // R10
    exit_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(exit_pending_o) && !in_claim_o && !in_beacon_o)
        |-> $past(tx_frame_done_i));
endmodule

bind cb_tx_arbiter cbta_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .fn_claim_i      (fn_claim_i),
    .fn_beacon_i     (fn_beacon_i),
    .req_claim_i     (req_claim_i),
    .req_beacon_i    (req_beacon_i),
    .frame_ready_i   (frame_ready_i),
    .tx_frame_done_i (tx_frame_done_i),
    .rx_valid_i      (rx_valid_i),
    .rx_class_i      (rx_class_i),
    .in_claim_o      (in_claim_o),
    .in_beacon_o     (in_beacon_o),
    .tx_sel_o        (tx_sel_o),
    .exit_pending_o  (exit_pending_o),
    .rx_evt_valid_o  (rx_evt_valid_o),
    .rx_evt_class_o  (rx_evt_class_o)
);

// File: tb/sim_cb_tx_arbiter.sv
`timescale 1ns/1ps
module sim_cb_tx_arbiter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fn_claim = 0, fn_beacon = 0, opt_wr = 0;
    logic       o_hc = 0, o_hb = 0, o_nr = 0;
    logic       rq_c = 0, rq_b = 0, rdy = 0, done = 0, rxv = 0;
    logic [2:0] rxc = 0;
    logic       in_claim, in_beacon, xp, ev;
    logic [1:0] sel;
    logic [2:0] evc;

    typedef struct packed {
        logic [1:0] st;
        logic [1:0] sel;
        logic       ev;
        logic [2:0] evc;
        logic       xp;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    finished = 0;
    bit    opt_pend = 0;

    always #2 clk = ~clk;

    cb_tx_arbiter u0 (
        .clk(clk), .rst(rst), .fn_claim_i(fn_claim), .fn_beacon_i(fn_beacon),
        .opt_wr_i(opt_wr), .opt_hold_claim_i(o_hc), .opt_hold_beacon_i(o_hb),
        .opt_no_repeat_i(o_nr), .req_claim_i(rq_c), .req_beacon_i(rq_b),
        .frame_ready_i(rdy), .tx_frame_done_i(done), .rx_valid_i(rxv),
        .rx_class_i(rxc), .in_claim_o(in_claim), .in_beacon_o(in_beacon),
        .tx_sel_o(sel), .exit_pending_o(xp), .rx_evt_valid_o(ev),
        .rx_evt_class_o(evc)
    );

    task automatic set_opt(input logic hc, input logic hb, input logic nr);
        o_hc = hc; o_hb = hb; o_nr = nr; opt_pend = 1;
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic step(input string tag, input logic fc, input logic fb,
                        input logic rc, input logic rb, input logic rd,
                        input logic dn, input logic rv, input logic [2:0] rcls,
                        input logic [1:0] e_st, input logic [1:0] e_sel,
                        input logic e_ev, input logic [2:0] e_evc,
                        input logic e_xp);
        exp_t e;
        @(negedge clk);
        fn_claim = fc; fn_beacon = fb; rq_c = rc; rq_b = rb; rdy = rd;
        done = dn; rxv = rv; rxc = rcls;
        opt_wr = opt_pend; opt_pend = 0;
        e.st = e_st; e.sel = e_sel; e.ev = e_ev; e.evc = e_evc; e.xp = e_xp;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expectation after every edge that has one pending.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.st = {in_beacon, in_claim}; a.sel = sel; a.ev = ev;
                a.evc = evc; a.xp = xp;
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: actual st=%0d sel=%0d ev=%0d evc=%0d xp=%0d expected st=%0d sel=%0d ev=%0d evc=%0d xp=%0d",
                             t, a.st, a.sel, a.ev, a.evc, a.xp,
                             e.st, e.sel, e.ev, e.evc, e.xp);
                end
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // Claim, no options
        step("R1 reset",        0,0, 0,0,0, 0, 0,0,  0,0,0,0,0);
        step("R2 enter claim",  1,0, 0,0,0, 0, 0,0,  1,1,0,0,0);
        step("R4 no host early",0,0, 1,0,1, 0, 0,0,  1,1,0,0,0);
        step("R4 host after int",0,0,1,0,1, 1, 0,0,  1,2,0,0,0);
        step("R5 held mid frame",0,0,1,0,1, 0, 0,0,  1,2,0,0,0);
        step("R3 no req internal",0,0,0,0,1,1, 0,0,  1,1,0,0,0);
        step("R4 host again",   0,0, 1,0,1, 1, 0,0,  1,2,0,0,0);
        step("R9 R6 event ends svc",0,0,1,0,1,0,1,0, 1,2,1,0,0);
        step("R9 back to int",  0,0, 1,0,1, 1, 0,0,  1,1,0,0,0);
        step("R9 host after int",0,0,1,0,1, 1, 0,0,  1,2,0,0,0);
        step("R10 own claim",   0,0, 1,0,1, 0, 1,2,  1,2,1,2,1);
        step("R10 exit",        0,0, 1,0,1, 1, 0,0,  0,0,0,0,0);
        step("R6 idle no report",0,0,0,0,0, 0, 1,1,  0,0,0,0,0);
        // Beacon with no-repeat
        set_opt(0,0,1);
        step("R2 enter beacon", 0,1, 0,0,0, 0, 0,0,  2,1,0,0,0);
        step("R4 beacon host",  0,0, 0,1,1, 1, 0,0,  2,2,0,0,0);
        step("R7 ignore cls4",  0,0, 0,1,1, 0, 1,4,  2,2,0,0,0);
        step("R7 ignore cls2",  0,0, 0,1,1, 0, 1,2,  2,2,0,0,0);
        step("R7 pass cls1",    0,0, 0,1,1, 0, 1,1,  2,2,1,1,0);
        step("R9 svc ended",    0,0, 0,1,1, 1, 0,0,  2,1,0,0,0);
        step("R6 report cls2",  0,0, 0,1,1, 0, 1,2,  2,1,1,2,0);
        set_opt(0,1,1);
        step("R4 host resumes", 0,0, 0,1,1, 1, 0,0,  2,2,0,0,0);
        step("R8 ignore cls3",  0,0, 0,1,1, 0, 1,3,  2,2,0,0,0);
        step("R8 ignore cls1",  0,0, 0,1,1, 0, 1,1,  2,2,0,0,0);
        step("R3 req drop",     0,0, 0,0,1, 1, 0,0,  2,1,0,0,0);
        step("R10 own beacon",  0,0, 0,1,1, 0, 1,3,  2,1,1,3,1);
        step("R11 hold host",   0,0, 0,1,1, 1, 0,0,  2,2,0,0,1);
        step("R11 hold host 2", 0,0, 0,1,1, 1, 0,0,  2,2,0,0,1);
        step("R11 exit on drop",0,0, 0,0,1, 1, 0,0,  0,0,0,0,0);
        // Claim hold, switching
        set_opt(1,0,0);
        step("R2 beacon wins",  1,1, 0,0,0, 0, 0,0,  2,1,0,0,0);
        step("R12 switch claim",1,0, 0,0,0, 0, 0,0,  1,1,0,0,0);
        step("R4 host in claim",0,0, 1,0,1, 1, 0,0,  1,2,0,0,0);
        step("R11 held own claim",0,0,1,0,1,0, 1,2,  1,2,1,2,1);
        step("R11 keep host",   0,0, 1,0,1, 1, 0,0,  1,2,0,0,1);
        step("R12 switch beacon",0,1,0,1,1, 0, 0,0,  2,2,0,0,0);
        step("R12 int after switch",0,0,0,1,1,1,0,0, 2,1,0,0,0);
        step("R12 host after int",0,0,0,1,1,1, 0,0,  2,2,0,0,0);
        step("R5 idle tail",    0,0, 0,1,1, 0, 0,0,  2,2,0,0,0);
        repeat (3) @(posedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule